// File: doc/BRIEF.md
# ECC Error Capture and Status Logger

This block sits beside the DRAM datapath of a memory controller and records ECC failures for software. The datapath raises a correctable-error event or an uncorrectable-error event for one cycle. With the event it presents the failing 4 KiB block number, the 8-bit ECC syndrome and the channel (0 or 1) the data came from. The block keeps sticky status flags, one per error class, and latches the details of the logged error into read-only capture registers. A third, non-DRAM lock error arrives as a plain event input and only sets its own flag.

Software reads and writes the registers through a simple indexed port. Status flags are cleared by writing 1 to them. A command register selects which error classes raise a one-cycle error-signal pulse toward the system. Capture follows a fixed precedence. The first ECC error is logged. An uncorrectable error replaces the details of a correctable error that is still pending. A correctable error never disturbs a logged error, and a second uncorrectable error never displaces the first.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every register reads zero and `serrPulse` is low.
- R2: Status is read at index 0. A CE event sets bit 0, a UE event sets bit 7 and a lock event sets bit 9. Each bit stays set until software clears it, and all other status bits read zero.
- R3: A write to index 0 clears each of bits 0, 7 and 9 whose write-data bit is 1. Write-data bits of 0 leave the status unchanged.
- R4: When a clearing write and a new event for the same status bit fall in one cycle, the bit ends up set.
- R5: When no ECC status bit is set, an ECC event captures its details. Index 2 returns the block number in bits 31:12 with bits 11:0 zero. Index 3 returns the syndrome in bits 7:0. Index 4 returns the channel in bit 0, with all other bits zero.
- R6: A CE event leaves the captured details unchanged while the CE or UE status bit is set. The lock bit does not block capture.
- R7: A UE event captures its details when the UE status bit is clear, even if a CE is pending, and both ECC bits then read set. A UE event while the UE bit is set changes nothing in the capture.
- R8: A CE and a UE event in the same cycle set both status bits and capture the presented details.
- R9: The command register is at index 1. Bit 7 enables signalling on CE, bit 8 on UE and bit 9 on lock. These three bits are writable and all others read zero.
- R10: `serrPulse` is high for exactly the one cycle after the clock edge at which an enabled class sets a status bit that was clear. An event on a disabled class, or on a bit that is already set, gives no pulse.
- R11: Writes to indices 2, 3 and 4 have no effect on the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ceEvt | input | 1 | Correctable ECC error event, one cycle |
| ueEvt | input | 1 | Uncorrectable ECC error event, one cycle |
| lockEvt | input | 1 | Non-DRAM lock error event |
| evtBlock | input | 20 | Failing block number (address bits 31:12) |
| evtSyndrome | input | 8 | ECC syndrome of the event |
| evtChan | input | 1 | Channel of the event |
| regAddr | input | 3 | Register index |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| serrPulse | output | 1 | One-cycle error-signal pulse |

## Verification
The bench goes after the capture precedence. It sends a CE after a CE, a UE over a pending CE, a UE over a pending UE, and a CE while only the lock flag is set. A design with the wrong priority would show overwritten or frozen address and syndrome fields. It drives a clear and a new event in the same cycle, which a clear-wins design would lose. It also writes zeros and ones over the reserved positions, which a design with loose masks would corrupt. The pulse is checked to be one cycle long and to stay silent for disabled classes and for flags that are already set. A level-driven design, or one that fires on every event, would fail these checks.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;

  // Error classes, in the order used by every per-class vector.
  localparam int NCLS     = 3;
  localparam int CLS_CE   = 0;
  localparam int CLS_UE   = 1;
  localparam int CLS_LOCK = 2;

  // Bit positions of each class in the status and command registers.
  localparam int ST_POS  [NCLS] = '{0, 7, 9};
  localparam int CMD_POS [NCLS] = '{7, 8, 9};

  typedef enum logic [2:0] {
    RIDX_STATUS = 3'd0,
    RIDX_CMD    = 3'd1,
    RIDX_ADDR   = 3'd2,
    RIDX_SYN    = 3'd3,
    RIDX_CHAN   = 3'd4
  } regIdx_e;

  // Control -> datapath.
  typedef struct packed {
    logic            capLoad;
    logic [NCLS-1:0] status;
  } ctrlStrobe_t;

  // Datapath -> control.
  typedef struct packed {
    logic [NCLS-1:0] clr;
    logic [NCLS-1:0] en;
  } dpStrobe_t;

endpackage

// File: rtl/ecclog_ctrl.sv
module ecclog_ctrl
  import ecclog_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLS-1:0] evtVec,
  input  dpStrobe_t       fromDp,
  output ctrlStrobe_t     toDp,
  output logic            serrPulse
);

  logic [NCLS-1:0] stReg;
  logic [NCLS-1:0] newSet;

  // One sticky flag per class; a same-cycle event beats a clear.
  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    always_ff @(posedge clk) begin
      if (rst) stReg[k] <= 1'b0;
      else     stReg[k] <= evtVec[k] | (stReg[k] & ~fromDp.clr[k]);
    end
    assign newSet[k] = evtVec[k] & ~stReg[k];

    // R4: an event always leaves its flag set
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
      evtVec[k] |=> stReg[k]);
    // R3: a clear without an event empties the flag
    a_r3_clear_works: assert property (@(posedge clk) disable iff (rst)
      (fromDp.clr[k] && !evtVec[k]) |=> !stReg[k]);
    // R2: without a clear the flag holds
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
      (stReg[k] && !fromDp.clr[k]) |=> stReg[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) serrPulse <= 1'b0;
    else     serrPulse <= |(newSet & fromDp.en);
  end

  // UE capture unless a UE is logged; CE capture only into an empty log.
  assign toDp.capLoad = (evtVec[CLS_UE] & ~stReg[CLS_UE])
                      | (evtVec[CLS_CE] & ~stReg[CLS_CE] & ~stReg[CLS_UE]);
  assign toDp.status  = stReg;

  // R10: every pulse traces back to an enabled event
  a_r10_serr_cause: assert property (@(posedge clk) disable iff (rst)
    serrPulse |-> $past(|(evtVec & fromDp.en)));
  // R8: simultaneous ECC events set both flags
  a_r8_both_set: assert property (@(posedge clk) disable iff (rst)
    (evtVec[CLS_CE] && evtVec[CLS_UE]) |=> (stReg[CLS_CE] && stReg[CLS_UE]));

endmodule

// File: rtl/ecclog_dp.sv
module ecclog_dp
  import ecclog_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SYN_W      = 8,
  parameter int CTL_W      = 16,
  parameter int RD_W       = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctrlStrobe_t                  fromCtrl,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] evtBlock,
  input  logic [SYN_W-1:0]             evtSyn,
  input  logic                         evtChan,
  input  logic [2:0]                   regAddr,
  input  logic                         regWe,
  input  logic [CTL_W-1:0]             regWdata,
  output dpStrobe_t                    toCtrl,
  output logic [RD_W-1:0]              regRdata
);

  localparam int BLK_W = ADDR_W - PAGE_SHIFT;

  logic [BLK_W-1:0] capBlock;
  logic [SYN_W-1:0] capSyn;
  logic             capChan;
  logic [NCLS-1:0]  cmdEn;
  logic             stWr;
  logic             cmdWr;
  logic             unusedWdata;

  assign stWr        = regWe && (regAddr == RIDX_STATUS);
  assign cmdWr       = regWe && (regAddr == RIDX_CMD);
  assign unusedWdata = ^regWdata;

  for (genvar k = 0; k < NCLS; k++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (rst)        cmdEn[k] <= 1'b0;
      else if (cmdWr) cmdEn[k] <= regWdata[CMD_POS[k]];
    end
    assign toCtrl.clr[k] = stWr & regWdata[ST_POS[k]];
  end
  assign toCtrl.en = cmdEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      capBlock <= '0;
      capSyn   <= '0;
      capChan  <= 1'b0;
    end else if (fromCtrl.capLoad) begin
      capBlock <= evtBlock;
      capSyn   <= evtSyn;
      capChan  <= evtChan;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regIdx_e'(regAddr))
      RIDX_STATUS:
        for (int k = 0; k < NCLS; k++) regRdata[ST_POS[k]] = fromCtrl.status[k];
      RIDX_CMD:
        for (int k = 0; k < NCLS; k++) regRdata[CMD_POS[k]] = cmdEn[k];
      RIDX_ADDR: regRdata[ADDR_W-1:PAGE_SHIFT] = capBlock;
      RIDX_SYN:  regRdata[SYN_W-1:0] = capSyn;
      RIDX_CHAN: regRdata[0] = capChan;
      default:   regRdata = '0;
    endcase
  end

  // R7 and R6: a logged UE freezes the capture
  a_r7_ue_pending_holds: assert property (@(posedge clk) disable iff (rst)
    fromCtrl.status[CLS_UE] |=> ($stable(capBlock) && $stable(capSyn) && $stable(capChan)));
  // R11: a write to a capture index does not load it
  a_r11_ro_capture: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr == RIDX_ADDR && !fromCtrl.capLoad) |=> $stable(capBlock));
  // R9: the command register only changes on its own write
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    !cmdWr |=> $stable(cmdEn));

endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecclog_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SYN_W      = 8,
  parameter int CTL_W      = 16,
  parameter int RD_W       = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ceEvt,
  input  logic                         ueEvt,
  input  logic                         lockEvt,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] evtBlock,
  input  logic [SYN_W-1:0]             evtSyndrome,
  input  logic                         evtChan,
  input  logic [2:0]                   regAddr,
  input  logic                         regWe,
  input  logic [CTL_W-1:0]             regWdata,
  output logic [RD_W-1:0]              regRdata,
  output logic                         serrPulse
);

  ctrlStrobe_t     c2d;
  dpStrobe_t       d2c;
  logic [NCLS-1:0] evtVec;

  always_comb begin
    evtVec           = '0;
    evtVec[CLS_CE]   = ceEvt;
    evtVec[CLS_UE]   = ueEvt;
    evtVec[CLS_LOCK] = lockEvt;
  end

  ecclog_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .evtVec    (evtVec),
    .fromDp    (d2c),
    .toDp      (c2d),
    .serrPulse (serrPulse)
  );

  ecclog_dp #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .SYN_W      (SYN_W),
    .CTL_W      (CTL_W),
    .RD_W       (RD_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .fromCtrl (c2d),
    .evtBlock (evtBlock),
    .evtSyn   (evtSyndrome),
    .evtChan  (evtChan),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .toCtrl   (d2c),
    .regRdata (regRdata)
  );

endmodule

// File: tb/ecc_err_logger_bench.sv
`timescale 1ns/1ps
module ecc_err_logger_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ceEvt = 0, ueEvt = 0, lockEvt = 0, evtChan = 0;
  logic [19:0] evtBlock = '0;
  logic [7:0]  evtSyndrome = '0;
  logic [2:0]  regAddr = '0;
  logic        regWe = 0;
  logic [15:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        serrPulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ecc_err_logger u_ecc_err_logger (
    .clk(clk), .rst(rst), .ceEvt(ceEvt), .ueEvt(ueEvt), .lockEvt(lockEvt),
    .evtBlock(evtBlock), .evtSyndrome(evtSyndrome), .evtChan(evtChan),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .serrPulse(serrPulse)
  );

  typedef struct packed {
    logic        ce, ue, lock, chan;
    logic [31:0] addr;
    logic [7:0]  syn;
    logic [15:0] clr;
    logic [15:0] expSt;
    logic [31:0] expAddr;
    logic [7:0]  expSyn;
    logic        expChan;
    logic        expSerr;
    logic [3:0]  req;
  } vec_t;

  // Command enables CE and UE signalling (0x0180) while the table runs.
  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1,0,0,1, 32'h12345ABC, 8'h3C, 16'h0000, 16'h0001, 32'h12345000, 8'h3C, 1, 1, 4'd5},  // R5 first CE
    '{1,0,0,0, 32'h0000F123, 8'h11, 16'h0000, 16'h0001, 32'h12345000, 8'h3C, 1, 0, 4'd6},  // R6
    '{0,1,0,0, 32'hABCDE777, 8'h55, 16'h0000, 16'h0081, 32'hABCDE000, 8'h55, 0, 1, 4'd7},  // R7 UE over CE
    '{1,0,0,1, 32'h00000001, 8'h77, 16'h0000, 16'h0081, 32'hABCDE000, 8'h55, 0, 0, 4'd6},  // R6
    '{0,1,0,1, 32'h22222000, 8'h66, 16'h0000, 16'h0081, 32'hABCDE000, 8'h55, 0, 0, 4'd7},  // R7 UE over UE
    '{0,0,0,0, 32'h00000000, 8'h00, 16'h0081, 16'h0000, 32'hABCDE000, 8'h55, 0, 0, 4'd3},  // R3
    '{0,0,1,0, 32'h00000000, 8'h00, 16'h0000, 16'h0200, 32'hABCDE000, 8'h55, 0, 0, 4'd2},  // R2 lock, R10 disabled
    '{1,0,0,0, 32'h00007FFF, 8'hA5, 16'h0000, 16'h0201, 32'h00007000, 8'hA5, 0, 1, 4'd6},  // R6 lock does not block
    '{1,0,0,1, 32'h99999999, 8'hE1, 16'h0001, 16'h0201, 32'h00007000, 8'hA5, 0, 0, 4'd4},  // R4 set wins
    '{0,0,0,0, 32'h00000000, 8'h00, 16'h0201, 16'h0000, 32'h00007000, 8'hA5, 0, 0, 4'd3},  // R3
    '{1,1,0,1, 32'h0BAD0123, 8'hC3, 16'h0000, 16'h0081, 32'h0BAD0000, 8'hC3, 1, 1, 4'd8},  // R8
    '{0,0,0,0, 32'h00000000, 8'h00, 16'hFD7E, 16'h0081, 32'h0BAD0000, 8'hC3, 1, 0, 4'd3},  // R3 zeros keep
    '{0,0,0,0, 32'h00000000, 8'h00, 16'h0080, 16'h0001, 32'h0BAD0000, 8'hC3, 1, 0, 4'd3},  // R3 UE only
    '{0,1,0,1, 32'h0F0F0000, 8'h01, 16'h0000, 16'h0081, 32'h0F0F0000, 8'h01, 1, 1, 4'd7}   // R7
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #0.1;
    d = regRdata;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic step(input logic ce, input logic ue, input logic lk, input logic ch,
                      input logic [31:0] addr, input logic [7:0] syn, input logic [15:0] clr);
    ceEvt = ce; ueEvt = ue; lockEvt = lk; evtChan = ch;
    evtBlock = addr[31:12]; evtSyndrome = syn;
    regAddr = 3'd0; regWdata = clr; regWe = (clr != 0);
    @(posedge clk); @(negedge clk);
    ceEvt = 0; ueEvt = 0; lockEvt = 0; evtChan = 0;
    evtBlock = '0; evtSyndrome = '0; regWe = 0; regWdata = '0;
  endtask

  task automatic checkAllZero(input string req);
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      readReg(3'(a), d);
      chk(req, $sformatf("reg %0d after reset", a), d, 32'h0);
    end
    chk(req, "serrPulse after reset", {31'b0, serrPulse}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkAllZero("R1");

    regWrite(3'd1, 16'h0180);
    readReg(3'd1, d); chk("R9", "command readback", d, 32'h0000_0180);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].ce, VECS[i].ue, VECS[i].lock, VECS[i].chan, VECS[i].addr, VECS[i].syn, VECS[i].clr);
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d serr", i), {31'b0, serrPulse}, {31'b0, VECS[i].expSerr});
      readReg(3'd0, d); chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d status", i), d, {16'b0, VECS[i].expSt});
      readReg(3'd2, d); chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d addr", i), d, VECS[i].expAddr);
      readReg(3'd3, d); chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d syn", i), d, {24'b0, VECS[i].expSyn});
      readReg(3'd4, d); chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d chan", i), d, {31'b0, VECS[i].expChan});
    end

    // R11: capture registers ignore writes
    regWrite(3'd2, 16'hFFFF);
    regWrite(3'd3, 16'hFFFF);
    regWrite(3'd4, 16'hFFFF);
    readReg(3'd2, d); chk("R11", "addr after write", d, 32'h0F0F0000);
    readReg(3'd3, d); chk("R11", "syn after write", d, 32'h01);
    readReg(3'd4, d); chk("R11", "chan after write", d, 32'h1);

    // R3: clear every flag at once
    regWrite(3'd0, 16'h0281);
    readReg(3'd0, d); chk("R3", "status all cleared", d, 32'h0);

    // R10: disabled class gives no pulse, still logs (R5)
    regWrite(3'd1, 16'h0000);
    step(1, 0, 0, 0, 32'h44444ABC, 8'h99, 16'h0);
    chk("R10", "no pulse when disabled", {31'b0, serrPulse}, 32'h0);
    readReg(3'd0, d); chk("R2", "CE flag set", d, 32'h1);
    readReg(3'd2, d); chk("R5", "capture into empty log", d, 32'h44444000);

    // R10: lock enabled, pulse lasts one cycle
    regWrite(3'd1, 16'h0200);
    step(0, 0, 1, 0, 32'h0, 8'h0, 16'h0);
    chk("R10", "lock pulse", {31'b0, serrPulse}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R10", "pulse one cycle", {31'b0, serrPulse}, 32'h0);
    readReg(3'd0, d); chk("R2", "CE and lock flags", d, 32'h0201);

    // R9: only bits 7..9 of the command register are kept
    regWrite(3'd1, 16'hFFFF);
    readReg(3'd1, d); chk("R9", "command reserved bits", d, 32'h0380);

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    checkAllZero("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule